// File: doc/BRIEF.md
# Playback Millisecond Time Stamp

This block keeps the elapsed playing time of an audio stream as a 24-bit count of milliseconds, so that lyrics or other cues can be lined up with the sound. An external millisecond tick makes it advance while the player is playing. A start from the stopped state clears it. It holds while paused or stopped. During fast forward and rewind the audio processor writes positions into it through a seek port.

A host with an 8-bit bus sees the count as three byte registers: low at address 0, middle at address 1 and high at address 2. Both reads and writes are atomic across the three bytes. Reading the low byte freezes a copy of the whole count, and the middle and high bytes are then served from that copy. Written low and middle bytes wait in staging registers, and writing the high byte moves all 24 bits into the live count at once.

Top module: `play_time_stamp`

## Requirements
- R1: While reset is held low at a clock edge, the live count and the read data become zero.
- R2: In play mode (mode code 1), each cycle with `ms_tick` high adds one to the count. In stop mode (code 0) ticks are ignored and the count holds.
- R3: Incrementing from 0xFFFFFF gives 0x000000.
- R4: A cycle in which the mode is play and the previous cycle's mode was stop sets the count to zero and ignores any tick. Entering play from any other mode does not clear the count.
- R5: In pause mode (code 2) the count holds, whatever `ms_tick` and the seek port do.
- R6: In fast forward (code 3) or rewind (code 4), `seek_valid` high loads `seek_value` into the count at the next edge. In every other mode the seek port has no effect.
- R7: A read at address 0 returns the live low byte and captures the full count. Reads at addresses 1 and 2 return bits 15:8 and 23:16 of that capture, even if the live count has moved since.
- R8: Writes to address 0 (bits 7:0) and address 1 (bits 15:8) change only staging registers. A write to address 2 loads {write data, staged middle, staged low} into the count at the next edge.
- R9: A commit through address 2 takes priority over a tick, a seek load and the stop-to-play clear arriving in the same cycle.
- R10: Read data is registered and appears on the edge after a read strobe. It holds between reads, and a read at address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per elapsed millisecond |
| mode | input | 3 | Player mode: 0 stop, 1 play, 2 pause, 3 fast forward, 4 rewind |
| seek_valid | input | 1 | Audio processor loads a new position |
| seek_value | input | 24 | Position to load, in milliseconds |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 2 | Byte register select |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid the cycle after `bus_rd` |
| time_value | output | 24 | Live count |

## Verification
A host commit of the high byte can land in the same cycle as a millisecond tick, a seek load or the stop-to-play clear. The low-byte read snapshot can also fall between a tick and the later middle-byte read. Directed sequences set up each of these collisions on purpose: a commit with a tick in play, a commit with a seek in fast forward, a commit on the first play cycle after stop, and a tick between the low and middle reads. A long random run then mixes modes, ticks, seeks and bus traffic so that such collisions also occur by chance. A cycle-by-cycle reference model in the bench judges every result, and it places the commit above all other sources.

// File: rtl/pts_pkg.sv
// Package: shared encodings for the playback time stamp block.
// Assumes the count width is a whole number of bytes.
package pts_pkg;

    localparam int BYTE_W = 8;

    // Player mode codes as seen on the mode port.
    typedef enum logic [2:0] {
        PM_STOP   = 3'd0,
        PM_PLAY   = 3'd1,
        PM_PAUSE  = 3'd2,
        PM_FFWD   = 3'd3,
        PM_REWIND = 3'd4
    } play_mode_e;

endpackage

// File: rtl/pts_counter.sv
// Module: pts_counter
// Holds the live millisecond count and applies one update source per cycle.
// Priority from highest: host commit, stop-to-play clear, seek load in
// fast forward or rewind, tick increment in play. Otherwise the count holds.
// Assumes ms_tick is a single-cycle pulse and mode is already synchronous.
module pts_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic [2:0]       mode,
    input  logic             seek_valid,
    input  logic [CNT_W-1:0] seek_value,
    input  logic             commit,
    input  logic [CNT_W-1:0] commit_val,
    output logic [CNT_W-1:0] count
);
    import pts_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [2:0]       prev_mode_q;
    logic             start_play;
    logic             seek_ok;

    assign start_play = (mode == PM_PLAY) && (prev_mode_q == PM_STOP);
    assign seek_ok    = seek_valid && ((mode == PM_FFWD) || (mode == PM_REWIND));

    // Pick the next count from the highest-priority active source.
    always_comb begin
        cnt_d = cnt_q;
        if (commit) begin
            cnt_d = commit_val;
        end else if (start_play) begin
            cnt_d = '0;
        end else if (seek_ok) begin
            cnt_d = seek_value;
        end else if ((mode == PM_PLAY) && ms_tick) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    // Register the count and the previous mode for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            prev_mode_q <= PM_STOP;
        end else begin
            cnt_q       <= cnt_d;
            prev_mode_q <= mode;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/pts_write_stage.sv
// Module: pts_write_stage
// Stages every host-written byte below the top byte. A write to the top
// byte address forms the full value and raises a one-cycle commit.
// Assumes at most one bus write per cycle and byte k at address k.
module pts_write_stage #(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]       wdata,
    output logic             commit,
    output logic [CNT_W-1:0] commit_val
);
    localparam int NB    = CNT_W / pts_pkg::BYTE_W;
    localparam int STG_W = CNT_W - pts_pkg::BYTE_W;

    logic [STG_W-1:0] stage_q;

    for (genvar g = 0; g < NB - 1; g++) begin : g_stage
        // Capture the staged byte when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g*8 +: 8] <= '0;
            end else if (wr_en && (addr == ADDR_W'(g))) begin
                stage_q[g*8 +: 8] <= wdata;
            end
        end
    end

    assign commit     = wr_en && (addr == ADDR_W'(NB - 1));
    assign commit_val = {wdata, stage_q};

endmodule

// File: rtl/pts_read_port.sv
// Module: pts_read_port
// Serves host byte reads. A low-byte read returns the live low byte and
// snapshots the upper bytes; higher addresses return the snapshot. Read
// data is registered and held between reads. Unmapped addresses read zero.
module pts_read_port #(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  live,
    output logic [7:0]        rdata
);
    localparam int NB = CNT_W / pts_pkg::BYTE_W;

    logic [CNT_W-1:8] snap_q;
    logic [7:0]       rd_byte;
    logic [7:0]       rdata_q;

    // Select the byte for the current read address.
    always_comb begin
        rd_byte = '0;
        if (addr == '0) begin
            rd_byte = live[7:0];
        end
        for (int k = 1; k < NB; k++) begin
            if (addr == ADDR_W'(k)) begin
                rd_byte = snap_q[k*8 +: 8];
            end
        end
    end

    // Freeze the upper bytes when the low byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (rd_en && (addr == '0)) begin
            snap_q <= live[CNT_W-1:8];
        end
    end

    // Register the read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_byte;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/play_time_stamp.sv
// Module: play_time_stamp (top)
// Playback millisecond time stamp with atomic byte-wide host access.
// Assumes a host that reads low byte first and writes high byte last.
module play_time_stamp #(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic [2:0]        mode,
    input  logic              seek_valid,
    input  logic [CNT_W-1:0]  seek_value,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [CNT_W-1:0]  time_value
);
    logic             commit;
    logic [CNT_W-1:0] commit_val;

    pts_write_stage #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_wstage (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .commit     (commit),
        .commit_val (commit_val)
    );

    pts_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .ms_tick    (ms_tick),
        .mode       (mode),
        .seek_valid (seek_valid),
        .seek_value (seek_value),
        .commit     (commit),
        .commit_val (commit_val),
        .count      (time_value)
    );

    pts_read_port #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rport (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (bus_rd),
        .addr  (bus_addr),
        .live  (time_value),
        .rdata (bus_rdata)
    );

endmodule

// File: rtl/pts_checker.sv
// Module: pts_checker
// Temporal checks on the playback time stamp ports, attached by bind.
// Keeps its own copy of the previous mode to spot the stop-to-play edge.
module pts_checker #(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ms_tick,
    input logic [2:0]        mode,
    input logic              seek_valid,
    input logic [CNT_W-1:0]  seek_value,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [CNT_W-1:0]  time_value
);
    import pts_pkg::*;
    localparam int NB = CNT_W / BYTE_W;

    logic [2:0] seen_mode_q;
    logic       hi_write;
    logic       from_stop;

    // Track the mode of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_mode_q <= PM_STOP;
        else        seen_mode_q <= mode;
    end

    assign hi_write  = bus_wr && (bus_addr == ADDR_W'(NB - 1));
    assign from_stop = (seen_mode_q == PM_STOP);

    assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_PLAY && !from_stop && ms_tick && !hi_write)
        |=> time_value == CNT_W'($past(time_value) + 1));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_PLAY && !from_stop && ms_tick && !hi_write && time_value == '1)
        |=> time_value == '0);

    assert_start_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_PLAY && from_stop && !hi_write) |=> time_value == '0);

    assert_pause_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_PAUSE && !hi_write) |=> $stable(time_value));

    assert_seek_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seek_valid && (mode == PM_FFWD || mode == PM_REWIND) && !hi_write)
        |=> time_value == $past(seek_value));

    assert_low_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == '0) |=> bus_rdata == $past(time_value[7:0]));

    assert_commit_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hi_write |=> time_value[CNT_W-1 -: 8] == $past(bus_wdata));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    if (NB < (1 << ADDR_W)) begin : g_unmapped
        assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && bus_addr == ADDR_W'(1 << ADDR_W) - ADDR_W'(1)) |=> bus_rdata == 8'h00);
    end

endmodule

bind play_time_stamp pts_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_pts_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ms_tick    (ms_tick),
    .mode       (mode),
    .seek_valid (seek_valid),
    .seek_value (seek_value),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .time_value (time_value)
);

// File: tb/test_play_time_stamp.sv
// Bench: directed corner cases plus seeded random traffic, checked every
// cycle against a reference model built from the requirements.
module test_play_time_stamp;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ms_tick;
    logic [2:0]  mode;
    logic        seek_valid;
    logic [23:0] seek_value;
    logic        bus_wr;
    logic        bus_rd;
    logic [1:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [23:0] time_value;

    int n_checks = 0;
    int n_fails  = 0;
    int n_cycles = 0;

    // Reference model state.
    logic [23:0] m_cnt;
    logic [2:0]  m_prev;
    logic [15:0] m_stage;
    logic [23:8] m_snap;
    logic [7:0]  m_rdata;
    string       m_cnt_tag;
    string       m_rd_tag;

    play_time_stamp i_play_time_stamp (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .mode(mode),
        .seek_valid(seek_valid), .seek_value(seek_value),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .time_value(time_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Next count from the requirements (R2, R3, R4, R5, R6, R8, R9).
    function automatic logic [23:0] exp_next(input logic [23:0] cnt, input logic [2:0] prev);
        if (bus_wr && bus_addr == 2'd2) return {bus_wdata, m_stage};
        if (mode == 3'd1 && prev == 3'd0) return 24'h0;
        if (seek_valid && (mode == 3'd3 || mode == 3'd4)) return seek_value;
        if (mode == 3'd1 && ms_tick) return cnt + 24'd1;
        return cnt;
    endfunction

    function automatic string cnt_tag(input logic [2:0] prev);
        if (bus_wr && bus_addr == 2'd2) return "R9";
        if (mode == 3'd1 && prev == 3'd0) return "R4";
        if (mode == 3'd3 || mode == 3'd4) return "R6";
        if (mode == 3'd2) return "R5";
        if (bus_wr) return "R8";
        return "R2";
    endfunction

    // Advance the model with the inputs present at this edge.
    task automatic model_step();
        logic [23:0] nxt;
        logic [7:0]  rb;
        if (!rst_n) begin
            m_cnt = '0; m_prev = 3'd0; m_stage = '0; m_snap = '0; m_rdata = '0;
            m_cnt_tag = "R1"; m_rd_tag = "R1";
            return;
        end
        nxt = exp_next(m_cnt, m_prev);
        m_cnt_tag = cnt_tag(m_prev);
        m_rd_tag = "R10";
        if (bus_rd) begin
            case (bus_addr)
                2'd0: rb = m_cnt[7:0];
                2'd1: rb = m_snap[15:8];
                2'd2: rb = m_snap[23:16];
                default: rb = 8'h00;
            endcase
            m_rdata = rb;
            m_rd_tag = (bus_addr == 2'd3) ? "R10" : "R7";
            if (bus_addr == 2'd0) m_snap = m_cnt[23:8];
        end
        if (bus_wr && bus_addr == 2'd0) m_stage[7:0]  = bus_wdata;
        if (bus_wr && bus_addr == 2'd1) m_stage[15:8] = bus_wdata;
        m_prev = mode;
        m_cnt  = nxt;
    endtask

    // One clock: model update at the edge, compare at the falling edge.
    task automatic cycle();
        @(posedge clk);
        model_step();
        n_cycles++;
        @(negedge clk);
        check(time_value === m_cnt, m_cnt_tag, time_value, m_cnt);
        check(bus_rdata === m_rdata, m_rd_tag, {16'h0, bus_rdata}, {16'h0, m_rdata});
    endtask

    task automatic idle();
        ms_tick = 0; seek_valid = 0; bus_wr = 0; bus_rd = 0;
    endtask

    task automatic set_mode(input logic [2:0] m);
        idle(); mode = m; cycle();
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            idle(); ms_tick = 1; cycle();
            idle(); cycle();
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
        idle(); bus_wr = 1; bus_addr = a; bus_wdata = d; cycle(); idle();
    endtask

    task automatic host_rd(input logic [1:0] a);
        idle(); bus_rd = 1; bus_addr = a; cycle(); idle();
    endtask

    task automatic load_value(input logic [23:0] v);
        host_wr(2'd0, v[7:0]); host_wr(2'd1, v[15:8]); host_wr(2'd2, v[23:16]);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired after %0d cycles", MAX_CYCLES);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        idle(); mode = 3'd0; seek_value = '0; bus_addr = '0; bus_wdata = '0;
        rst_n = 0;
        repeat (3) cycle();
        // R1: reset state
        check(time_value === 24'h0, "R1", time_value, 24'h0);
        check(bus_rdata === 8'h0, "R1", {16'h0, bus_rdata}, 24'h0);
        rst_n = 1;

        // R2: counting in play, ignoring ticks in stop
        set_mode(3'd1);
        tick_n(5);
        check(time_value === 24'd5, "R2", time_value, 24'd5);
        set_mode(3'd0);
        tick_n(3);
        check(time_value === 24'd5, "R2", time_value, 24'd5);

        // R5: pause holds with ticks and seeks present
        set_mode(3'd2);
        idle(); ms_tick = 1; seek_valid = 1; seek_value = 24'hABCDEF; cycle(); idle();
        check(time_value === 24'd5, "R5", time_value, 24'd5);

        // R4: pause to play keeps, stop to play clears
        set_mode(3'd1);
        tick_n(1);
        check(time_value === 24'd6, "R4", time_value, 24'd6);
        set_mode(3'd0);
        idle(); mode = 3'd1; ms_tick = 1; cycle(); idle();
        check(time_value === 24'd0, "R4", time_value, 24'd0);

        // R6: seek loads in fast forward, ignored in play
        set_mode(3'd3);
        idle(); seek_valid = 1; seek_value = 24'h123456; cycle(); idle();
        check(time_value === 24'h123456, "R6", time_value, 24'h123456);
        set_mode(3'd4);
        idle(); seek_valid = 1; seek_value = 24'h000777; cycle(); idle();
        check(time_value === 24'h000777, "R6", time_value, 24'h000777);
        set_mode(3'd1);
        idle(); seek_valid = 1; seek_value = 24'h999999; cycle(); idle();
        check(time_value === 24'h000777, "R6", time_value, 24'h000777);

        // R8: staging writes do not disturb the count, top write commits
        set_mode(3'd2);
        host_wr(2'd0, 8'hFE);
        host_wr(2'd1, 8'hFF);
        check(time_value === 24'h000777, "R8", time_value, 24'h000777);
        host_wr(2'd2, 8'hFF);
        check(time_value === 24'hFFFFFE, "R8", time_value, 24'hFFFFFE);

        // R3: wrap through all ones
        set_mode(3'd1);
        tick_n(1);
        check(time_value === 24'hFFFFFF, "R3", time_value, 24'hFFFFFF);
        tick_n(1);
        check(time_value === 24'h000000, "R3", time_value, 24'h000000);

        // R7: snapshot on low read survives a tick before the middle read
        set_mode(3'd2);
        load_value(24'h0000FF);
        set_mode(3'd1);
        host_rd(2'd0);
        check(bus_rdata === 8'hFF, "R7", {16'h0, bus_rdata}, 24'h0000FF);
        tick_n(1);
        check(time_value === 24'h000100, "R7", time_value, 24'h000100);
        host_rd(2'd1);
        check(bus_rdata === 8'h00, "R7", {16'h0, bus_rdata}, 24'h0);
        host_rd(2'd2);
        check(bus_rdata === 8'h00, "R7", {16'h0, bus_rdata}, 24'h0);

        // R9: commit against tick, seek and stop-to-play clear
        host_wr(2'd0, 8'h34); host_wr(2'd1, 8'h12);
        idle(); ms_tick = 1; bus_wr = 1; bus_addr = 2'd2; bus_wdata = 8'h56; cycle(); idle();
        check(time_value === 24'h561234, "R9", time_value, 24'h561234);
        set_mode(3'd3);
        idle(); seek_valid = 1; seek_value = 24'h0F0F0F;
        bus_wr = 1; bus_addr = 2'd2; bus_wdata = 8'hA5; cycle(); idle();
        check(time_value === 24'hA51234, "R9", time_value, 24'hA51234);
        set_mode(3'd0);
        idle(); mode = 3'd1; bus_wr = 1; bus_addr = 2'd2; bus_wdata = 8'h3C; cycle(); idle();
        check(time_value === 24'h3C1234, "R9", time_value, 24'h3C1234);

        // R10: unmapped address reads zero, data holds between reads
        host_rd(2'd0);
        host_rd(2'd3);
        check(bus_rdata === 8'h00, "R10", {16'h0, bus_rdata}, 24'h0);
        host_rd(2'd0);
        set_mode(3'd1);
        tick_n(2);
        check(bus_rdata === m_rdata, "R10", {16'h0, bus_rdata}, {16'h0, m_rdata});

        // Random traffic with collisions among all sources.
        for (int i = 0; i < 4000; i++) begin
            idle();
            if ($urandom_range(15) == 0) mode = 3'($urandom_range(4));
            ms_tick    = ($urandom_range(2) == 0);
            seek_valid = ($urandom_range(5) == 0);
            seek_value = 24'($urandom);
            case ($urandom_range(5))
                0: begin bus_wr = 1; bus_addr = 2'($urandom_range(3)); end
                1: begin bus_rd = 1; bus_addr = 2'($urandom_range(3)); end
                default: bus_addr = 2'($urandom_range(3));
            endcase
            bus_wdata = 8'($urandom);
            cycle();
        end
        idle();
        cycle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule